// File: doc/BRIEF.md
# Serial Bridge-Sensor ADC Readout Controller

This block reads results from an external 24-bit bridge-sensor converter over a two-wire link. The block drives the serial clock. The converter drives the data line. When it is armed, the block watches the synchronized data line for a high-to-low edge, which means a conversion is ready. On that edge it generates a burst of fixed-period clock pulses and shifts the result in, most significant bit first. Once the 24 data bits are in, the burst continues with one to three trailing pulses. The total pulse count chosen at start tells the converter which gain or channel to use for its next conversion.

A complete result is sign-extended and presented with a one-cycle valid strobe. A falling-edge counter runs separately from bit capture. If it reaches 24 while fewer than 24 bits have been taken, the readout is abandoned and an error strobe carries the partial word. In single-shot mode the clock is parked high after the burst, which powers the converter down. In continuous mode the clock returns low and ready detection is re-armed. A stop request parks the clock high and keeps it there for a guaranteed minimum time.

States:
- `S_IDLE`: clock high, converter powered down.
- `S_HOLD`: clock high during the minimum power-down time.
- `S_ARMED`: clock low, waiting for the ready edge.
- `S_BURST`: clock pulses running.

Transitions:
- `t_start`: S_IDLE or S_ARMED to S_ARMED.
- `t_ready`: S_ARMED to S_BURST.
- `t_end`: S_BURST to S_HOLD when single-shot, or to S_ARMED when continuous.
- `t_hold_done`: S_HOLD to S_IDLE.
- `t_stop`: any state to S_HOLD.

Top module: `bridge_adc_reader`

## Requirements
- R1: After reset `sck_o` is high, `valid_o` and `err_o` are low and `data_o` is zero.
- R2: A `start_i` pulse in the idle or armed state drives `sck_o` low one cycle later and arms ready detection.
- R3: A high-to-low edge on the synchronized data line while armed starts a burst. Each pulse lasts PERIOD cycles, and the clock is high for the first HIGH cycles of it. The pulse count comes from `mode_i` at start: code 0 gives 25 pulses, 1 gives 26, 2 gives 27 and 3 gives 25.
- R4: Data is sampled SAMPLE_OFS cycles after each rising clock edge. The first bit is bit 23. At the end of the burst a full 24-bit word appears on `data_o`, sign-extended to 32 bits, with `valid_o` high for exactly one cycle. `valid_o` and `err_o` are never high together.
- R5: In single-shot mode (`single_i`=1 at start) `sck_o` is high from the end of the burst onward. Later ready edges start no burst until a new start.
- R6: In continuous mode (`single_i`=0 at start) `sck_o` is low after the burst, and the next ready edge is read without another start.
- R7: Falling edges on the data line during a burst do not start another burst. Each conversion yields exactly one strobe.
- R8: If the 24th falling clock edge comes before the 24th bit is captured, capture stops. At the end of the burst `err_o` pulses for one cycle with the partial word zero-extended on `data_o`, and `valid_o` stays low.
- R9: A `stop_i` pulse drives `sck_o` high on the next cycle and abandons any burst without a strobe. `sck_o` then stays high for at least PD_TICKS cycles, and `start_i` is ignored during that window. After the window a start is accepted again. Single-shot completion enters the same window.
- R10: `mode_i` and `single_i` are latched at start. Changing them later has no effect on the pulse count or the end-of-burst clock level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Wake converter and arm ready detection |
| stop_i | input | 1 | Power-down request |
| single_i | input | 1 | 1 = single-shot, 0 = continuous (latched at start) |
| mode_i | input | 2 | Trailing-pulse code (latched at start) |
| sdat_i | input | 1 | Serial data / ready line from converter |
| sck_o | output | 1 | Serial clock to converter |
| data_o | output | 32 | Result word (sign-extended) or partial word on error |
| valid_o | output | 1 | One-cycle strobe for a complete result |
| err_o | output | 1 | One-cycle strobe for an abandoned readout |

## Verification
The bench builds two instances with PERIOD=8, HIGH=4 and PD_TICKS=20. The instances share the stimulus and a single converter model, so bursts last a few hundred cycles and the hold window is short enough to test both ignored and accepted starts. One instance samples at SAMPLE_OFS=3, inside the high phase, and must return every word intact. The other samples at SAMPLE_OFS=6, after the falling edge, so its bit capture trails the edge counter by one. Every burst therefore drives it into the out-of-sync abort, which makes the partial-word error path observable. Every mode code is run, including the reserved one.

// File: rtl/bra_pkg.sv
package bra_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_ARMED,
        S_BURST
    } bra_state_e;

    // Total clock pulses in one burst for a trailing-pulse code.
    function automatic int unsigned burst_len(input logic [1:0] code, input int unsigned res);
        case (code)
            2'd1:    return res + 2;
            2'd2:    return res + 3;
            default: return res + 1;
        endcase
    endfunction

endpackage

// File: rtl/bra_sync.sv
module bra_sync #(
    parameter int    STAGES   = 2,
    parameter logic  RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bra_hold_timer.sv
module bra_hold_timer #(
    parameter int TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic done_o
);
    localparam int HW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clear_i || !run_i)  cnt_q <= '0;
        else if (!done_o)            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && !clear_i && (cnt_q == HW'(TICKS - 1));
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader #(
    parameter int RES         = 24,
    parameter int OUT_W       = 32,
    parameter int PERIOD      = 32,
    parameter int HIGH        = 16,
    parameter int SAMPLE_OFS  = 8,
    parameter int PD_TICKS    = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             single_i,
    input  logic [1:0]       mode_i,
    input  logic             sdat_i,
    output logic             sck_o,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o,
    output logic             err_o
);
    import bra_pkg::*;

    localparam int TICK_W = $clog2(PERIOD);
    localparam int BIT_W  = $clog2(RES + 1);
    localparam int PCNT_W = $clog2(RES + 4);
    localparam int EXT_W  = OUT_W - RES;

    bra_state_e        state_q, state_d;
    logic              sdat_s, sprev_q, ready_fall;
    logic              hold_done;
    logic              t_stop, t_start, t_ready, t_end, t_hold_done;
    logic              sck_q, single_q, abandon_q, valid_q, err_q;
    logic [TICK_W-1:0] tick_q;
    logic [PCNT_W-1:0] fall_q, pulses_q;
    logic [BIT_W-1:0]  bits_q;
    logic [RES-1:0]    shreg_q;
    logic [OUT_W-1:0]  data_q;
    logic              cap_now, burst_last;
    logic [BIT_W-1:0]  bits_after;

    bra_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sdat_i), .q_o(sdat_s)
    );

    bra_hold_timer #(.TICKS(PD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .run_i(state_q == S_HOLD),
        .clear_i(t_stop), .done_o(hold_done)
    );

    assign ready_fall = sprev_q && !sdat_s;
    assign cap_now    = (tick_q == TICK_W'(SAMPLE_OFS)) && (bits_q < BIT_W'(RES)) && !abandon_q;
    assign bits_after = bits_q + BIT_W'(cap_now);
    assign burst_last = (tick_q == TICK_W'(PERIOD - 1)) && (fall_q == pulses_q);

    // Transition conditions and next state
    always_comb begin
        t_stop      = stop_i;
        t_start     = start_i && !stop_i && (state_q == S_IDLE || state_q == S_ARMED);
        t_ready     = (state_q == S_ARMED) && !stop_i && !start_i && ready_fall;
        t_end       = (state_q == S_BURST) && !stop_i && burst_last;
        t_hold_done = (state_q == S_HOLD) && !stop_i && hold_done;
        state_d     = state_q;
        unique case (state_q)
            S_IDLE:  if (t_start)     state_d = S_ARMED;
            S_HOLD:  if (t_hold_done) state_d = S_IDLE;
            S_ARMED: if (t_ready)     state_d = S_BURST;
            S_BURST: if (t_end)       state_d = single_q ? S_HOLD : S_ARMED;
        endcase
        if (t_stop) state_d = S_HOLD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b1;
            sprev_q   <= 1'b1;
            tick_q    <= '0;
            fall_q    <= '0;
            bits_q    <= '0;
            shreg_q   <= '0;
            abandon_q <= 1'b0;
            pulses_q  <= PCNT_W'(RES + 1);
            single_q  <= 1'b1;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            sprev_q <= sdat_s;
            if (t_stop) begin
                sck_q <= 1'b1;
            end else if (t_start) begin
                sck_q    <= 1'b0;
                shreg_q  <= '0;
                bits_q   <= '0;
                pulses_q <= PCNT_W'(burst_len(mode_i, RES));
                single_q <= single_i;
            end else if (t_ready) begin
                sck_q     <= 1'b1;
                tick_q    <= '0;
                fall_q    <= '0;
                bits_q    <= '0;
                shreg_q   <= '0;
                abandon_q <= 1'b0;
            end else if (state_q == S_BURST) begin
                if (cap_now) begin
                    shreg_q[BIT_W'(RES - 1) - bits_q] <= sdat_s;
                    bits_q <= bits_after;
                end
                if (tick_q == TICK_W'(HIGH - 1)) begin
                    sck_q  <= 1'b0;
                    fall_q <= fall_q + 1'b1;
                    if ((fall_q + 1'b1 == PCNT_W'(RES)) && (bits_after < BIT_W'(RES)))
                        abandon_q <= 1'b1;
                end
                if (tick_q == TICK_W'(PERIOD - 1)) begin
                    tick_q <= '0;
                    if (burst_last) begin
                        sck_q <= single_q;
                        if (abandon_q) begin
                            err_q  <= 1'b1;
                            data_q <= {{EXT_W{1'b0}}, shreg_q};
                        end else begin
                            valid_q <= 1'b1;
                            data_q  <= {{EXT_W{shreg_q[RES-1]}}, shreg_q};
                        end
                    end else begin
                        sck_q <= 1'b1;
                    end
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

    assign sck_o   = sck_q;
    assign data_o  = data_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    // R4: the two result strobes never coincide
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !err_o);
    // R9: stop parks the clock high on the next cycle
    a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> sck_o);
    // R9: clock stays high for the whole hold window
    a_r9_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |-> sck_o);
    // R3: falling-edge count never passes the latched pulse count
    a_r3_fall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST) |-> (fall_q <= pulses_q));
    // R7: a strobe only follows a burst
    a_r7_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |-> ($past(state_q) == S_BURST));
    // R5 / R6: clock level after the burst follows the latched mode
    a_r5_single_park: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_o || err_o) && single_q) |-> sck_o);
    a_r6_cont_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_o || err_o) && !single_q) |-> !sck_o);
    // R8: an abandoned readout never reports as valid
    a_r8_abandon_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        abandon_q |-> !valid_o);

endmodule

// File: tb/tb_bridge_adc_reader.sv
module tb_bridge_adc_reader;
    localparam int P    = 8;
    localparam int H    = 4;
    localparam int OFS  = 3;
    localparam int LOFS = 6;
    localparam int PD   = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, single = 1'b1, dout = 1'b1;
    logic [1:0] mode = 2'd0;
    logic sck, v, e, sck_l, v_l, e_l;
    logic [31:0] d, d_l;

    always #4 clk = ~clk;

    bridge_adc_reader #(.PERIOD(P), .HIGH(H), .SAMPLE_OFS(OFS), .PD_TICKS(PD)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .single_i(single),
        .mode_i(mode), .sdat_i(dout), .sck_o(sck), .data_o(d), .valid_o(v), .err_o(e));

    bridge_adc_reader #(.PERIOD(P), .HIGH(H), .SAMPLE_OFS(LOFS), .PD_TICKS(PD)) dut_late (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .single_i(single),
        .mode_i(mode), .sdat_i(dout), .sck_o(sck_l), .data_o(d_l), .valid_o(v_l), .err_o(e_l));

    int checks = 0, errors = 0;

    // Converter model: presents the next bit after each rising clock edge
    logic [23:0] word_m = '0;
    int  idx_m = 0;
    bit  act_m = 1'b0;
    logic sck_pm = 1'b1;
    always @(negedge clk) begin
        if (act_m && sck && !sck_pm) begin
            if (idx_m < 24) dout = word_m[23 - idx_m];
            else            dout = 1'b1;
            idx_m = idx_m + 1;
        end
        sck_pm = sck;
    end

    function automatic logic [31:0] sext(input logic [23:0] w);
        return {{8{w[23]}}, w};
    endfunction
    function automatic logic [31:0] partial(input logic [23:0] w);
        return {8'h00, w[23:1], 1'b0};
    endfunction
    function automatic int npulses(input logic [1:0] c);
        return (c == 2'd1) ? 26 : (c == 2'd2) ? 27 : 25;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start(input bit sgl, input logic [1:0] m);
        repeat (PD + 4) @(negedge clk);
        single = sgl; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sck == 1'b0, "R2 start drives clock low", 32'(sck), 32'h0);
        mode = ~m;           // R10: later changes must not matter
        single = ~sgl;
    endtask

    task automatic run_conv(input logic [23:0] w, input int npul, input bit sgl);
        int rises = 0, nv = 0, ne = 0, extra = 0;
        logic [31:0] dv = '0, de = '0;
        bit pv, done = 1'b0;
        @(negedge clk);
        word_m = w; idx_m = 0; act_m = 1'b1; dout = 1'b0;
        pv = sck;
        for (int i = 0; i < 40 * P && !done; i++) begin
            @(negedge clk);
            if (v)   begin nv++; dv = d; end
            if (e_l) begin ne++; de = d_l; end
            if (e || v_l) extra++;
            if (v || e_l) done = 1'b1;
            else if (sck && !pv) rises++;
            pv = sck;
        end
        chk(nv == 1, "R4 one valid strobe", 32'(nv), 32'd1);
        chk(dv == sext(w), "R4 sign-extended word", dv, sext(w));
        chk(ne == 1 && de == partial(w), "R8 partial word on error", de, partial(w));
        chk(rises == npul, "R3/R10 pulse count", 32'(rises), 32'(npul));
        chk(sck == sgl, "R5/R6 clock level after burst", 32'(sck), 32'(sgl));
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (v || e || v_l || e_l) extra++;
        end
        chk(extra == 0, "R7 no extra strobes", 32'(extra), 32'h0);
    endtask

    initial begin
        #(8 * 190000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] m;
        logic [23:0] w;
        int bad;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(sck == 1'b1 && !v && !e && d == 32'h0, "R1 reset state", {d[30:0], sck}, 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Single-shot with latched mode, negative full-scale
        do_start(1'b1, 2'd0);
        run_conv(24'h800000, 25, 1'b1);

        // R5: a ready edge after single-shot is ignored
        act_m = 1'b0;
        repeat (PD + 4) @(negedge clk);
        dout = 1'b0;
        bad = 0;
        for (int i = 0; i < 12 * P; i++) begin
            @(negedge clk);
            if (!sck || v || e) bad++;
        end
        chk(bad == 0, "R5 ready ignored after single-shot", 32'(bad), 32'h0);
        dout = 1'b1;

        // Directed words across every mode code
        for (int c = 0; c < 4; c++) begin
            w = (c == 0) ? 24'h7FFFFF : (c == 1) ? 24'hFFFFFF : (c == 2) ? 24'h000000 : 24'h123456;
            do_start(1'b1, 2'(c));
            run_conv(w, npulses(2'(c)), 1'b1);
        end

        // Random single-shot conversions
        for (int k = 0; k < 8; k++) begin
            m = 2'($urandom_range(0, 3));
            w = 24'($urandom);
            do_start(1'b1, m);
            run_conv(w, npulses(m), 1'b1);
        end

        // Continuous run: no restart between conversions
        m = 2'($urandom_range(0, 2));
        do_start(1'b0, m);
        for (int k = 0; k < 6; k++) begin
            w = 24'($urandom);
            run_conv(w, npulses(m), 1'b0);
            repeat (5) @(negedge clk);
        end

        // R9: stop in the middle of a burst
        word_m = 24'hA5A5A5; idx_m = 0; act_m = 1'b1; dout = 1'b0;
        repeat (6 * P) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0; act_m = 1'b0; dout = 1'b1;
        chk(sck == 1'b1, "R9 stop parks clock high", 32'(sck), 32'h1);
        bad = 0;
        start = 1'b1;
        for (int i = 0; i < PD - 3; i++) begin
            @(negedge clk);
            if (!sck || v || e || v_l || e_l) bad++;
        end
        start = 1'b0;
        chk(bad == 0, "R9 hold window ignores start", 32'(bad), 32'h0);
        bad = 0;
        for (int i = 0; i < 30 * P; i++) begin
            @(negedge clk);
            if (v || e || v_l || e_l) bad++;
        end
        chk(bad == 0, "R9 abandoned burst gives no strobe", 32'(bad), 32'h0);
        do_start(1'b1, 2'd2);
        run_conv(24'h00C0DE, 27, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule